// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block chooses which of a set of interrupt lines should interrupt the processor. It starts from the lines that are pending and not masked. Each line gets a rank relative to a programmable rotation base, and rank 0 is the most urgent. A request is raised only when its best rank is strictly more urgent than the most urgent line already in service. The block holds the in-service vector, the rotation base and a rotate-on-auto-EOI flag.

An acknowledge strobe commits the current winner to service, unless auto-EOI is active. End-of-interrupt commands clear in-service bits, move the rotation base, or change the rotate flag. One line can be designated as the cascade input. In special fully nested mode, that line's in-service bit is left out of the current-priority calculation.

The pending vector comes from outside the block, so clearing a pending request after acknowledge is left to the requester.

Top module: `irq_rank_resolver`

## Requirements
- R1: After reset, `irq_o`=0, `line_o`=N_LINES-1, `isr_o`=0, the rotation base is 0 and the rotate-on-auto-EOI flag is clear.
- R2: A line's rank is (line − base) mod N_LINES, with rank 0 most urgent. `line_o` reports the eligible line of lowest rank. It reads N_LINES-1 whenever `irq_o` is 0.
- R3: Only lines with `pend_i`=1 and `mask_i`=0 are eligible. `irq_o` is 1 only if the best eligible rank is strictly lower than the best in-service rank (an empty in-service set ranks below everything).
- R4: While `sfn_i`=1, in-service bit CASC_LINE (default 2) is ignored when the current in-service priority is computed.
- R5: `ack_i` while a request is raised sets exactly the winner's bit in `isr_o`. `ack_i` with no request changes nothing, and `line_o` stays N_LINES-1, which is the spurious line.
- R6: With `auto_eoi_i`=1, an acknowledge leaves `isr_o` unchanged. If the rotate flag is also set, the base becomes (winner+1) mod N_LINES.
- R7: `cmd_code_i`=1 clears the in-service bit of lowest rank. Code 5 does the same and sets the base to that line+1.
- R8: Code 3 clears `isr_o[cmd_level_i]`. Code 7 does the same and sets the base to `cmd_level_i`+1.
- R9: Code 6 sets the base to `cmd_level_i`+1 and leaves `isr_o` untouched.
- R10: Code 0 clears the rotate flag and code 4 sets it. Code 2 has no effect.
- R11: When `ack_i` and `cmd_valid_i` are high in the same cycle, the acknowledge is applied and the command is ignored.
- R12: `irq_o` and `line_o` are registered. They reflect the state and inputs sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | N_LINES | Pending request per line |
| mask_i | input | N_LINES | Mask per line, 1 blocks the line |
| ack_i | input | 1 | Acknowledge strobe |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 3 | Command code (0..7, see R7–R10) |
| cmd_level_i | input | IDX_W | Line operand of the command |
| auto_eoi_i | input | 1 | Auto end-of-interrupt enable |
| sfn_i | input | 1 | Special fully nested enable |
| irq_o | output | 1 | Interrupt request to processor |
| line_o | output | IDX_W | Winning line, N_LINES-1 when idle |
| isr_o | output | N_LINES | In-service vector |

## Verification
The bench builds the block with its defaults: eight lines, cascade line 2. At that size every rotation base can be reached in a few commands. Setting the base from level 7 exercises the wrap from the top line back to 0. Auto-EOI rotation is driven from line 5 to base 6. These two points are where a modulo error in the rank or base arithmetic would show.

// File: rtl/irq_rank_pkg.sv
package irq_rank_pkg;
  typedef enum logic [2:0] {
    CMD_ROT_CLR    = 3'd0,
    CMD_EOI_TOP    = 3'd1,
    CMD_NOP        = 3'd2,
    CMD_EOI_LVL    = 3'd3,
    CMD_ROT_SET    = 3'd4,
    CMD_EOI_TOP_RB = 3'd5,
    CMD_SET_BASE   = 3'd6,
    CMD_EOI_LVL_RB = 3'd7
  } cmd_e;
endpackage

// File: rtl/irq_rank_find.sv
module irq_rank_find #(
  parameter int N_LINES = 8,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] vec_i,
  input  logic [IDX_W-1:0]   base_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   rank_o
);
  logic [N_LINES-1:0] rot;

  // rot[k] holds the line whose rank is k
  for (genvar k = 0; k < N_LINES; k++) begin : g_rot
    assign rot[k] = vec_i[IDX_W'(k) + base_i];
  end

  always_comb begin
    any_o  = 1'b0;
    rank_o = '0;
    for (int k = N_LINES - 1; k >= 0; k--) begin
      if (rot[k]) begin
        any_o  = 1'b1;
        rank_o = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/irq_state_next.sv
module irq_state_next
  import irq_rank_pkg::*;
#(
  parameter int N_LINES = 8,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] isr_i,
  input  logic [IDX_W-1:0]   base_i,
  input  logic               rot_i,
  input  logic               ack_i,
  input  logic               want_i,
  input  logic [IDX_W-1:0]   win_i,
  input  logic               auto_eoi_i,
  input  logic               cmd_valid_i,
  input  logic [2:0]         cmd_code_i,
  input  logic [IDX_W-1:0]   cmd_level_i,
  input  logic               top_any_i,
  input  logic [IDX_W-1:0]   top_line_i,
  output logic [N_LINES-1:0] isr_o,
  output logic [IDX_W-1:0]   base_o,
  output logic               rot_o
);
  always_comb begin
    isr_o  = isr_i;
    base_o = base_i;
    rot_o  = rot_i;
    if (ack_i) begin
      if (want_i) begin
        if (!auto_eoi_i) isr_o[win_i] = 1'b1;
        else if (rot_i)  base_o = win_i + IDX_W'(1);
      end
    end else if (cmd_valid_i) begin
      unique case (cmd_e'(cmd_code_i))
        CMD_ROT_CLR: rot_o = 1'b0;
        CMD_ROT_SET: rot_o = 1'b1;
        CMD_EOI_TOP, CMD_EOI_TOP_RB: begin
          if (top_any_i) begin
            isr_o[top_line_i] = 1'b0;
            if (cmd_code_i == CMD_EOI_TOP_RB) base_o = top_line_i + IDX_W'(1);
          end
        end
        CMD_EOI_LVL, CMD_EOI_LVL_RB: begin
          isr_o[cmd_level_i] = 1'b0;
          if (cmd_code_i == CMD_EOI_LVL_RB) base_o = cmd_level_i + IDX_W'(1);
        end
        CMD_SET_BASE: base_o = cmd_level_i + IDX_W'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_rank_resolver.sv
module irq_rank_resolver #(
  parameter int N_LINES   = 8,
  parameter int CASC_LINE = 2,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] pend_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic               ack_i,
  input  logic               cmd_valid_i,
  input  logic [2:0]         cmd_code_i,
  input  logic [IDX_W-1:0]   cmd_level_i,
  input  logic               auto_eoi_i,
  input  logic               sfn_i,
  output logic               irq_o,
  output logic [IDX_W-1:0]   line_o,
  output logic [N_LINES-1:0] isr_o
);
  localparam logic [IDX_W-1:0] IDLE_LINE = IDX_W'(N_LINES - 1);

  logic [N_LINES-1:0] isr_q, isr_n, elig, svc_vec;
  logic [IDX_W-1:0]   base_q, base_n;
  logic               rot_q, rot_n;
  logic               p_any, s_any, t_any, want;
  logic [IDX_W-1:0]   p_rank, s_rank, t_rank, p_line, t_line;

  assign elig = pend_i & ~mask_i;

  always_comb begin
    svc_vec = isr_q;
    if (sfn_i) svc_vec[CASC_LINE] = 1'b0;
  end

  irq_rank_find #(.N_LINES(N_LINES)) u_pend (
    .vec_i(elig), .base_i(base_q), .any_o(p_any), .rank_o(p_rank));
  irq_rank_find #(.N_LINES(N_LINES)) u_svc (
    .vec_i(svc_vec), .base_i(base_q), .any_o(s_any), .rank_o(s_rank));
  irq_rank_find #(.N_LINES(N_LINES)) u_top (
    .vec_i(isr_q), .base_i(base_q), .any_o(t_any), .rank_o(t_rank));

  assign p_line = p_rank + base_q;
  assign t_line = t_rank + base_q;
  assign want   = p_any && (!s_any || (p_rank < s_rank));

  irq_state_next #(.N_LINES(N_LINES)) u_next (
    .isr_i(isr_q), .base_i(base_q), .rot_i(rot_q),
    .ack_i(ack_i), .want_i(want), .win_i(p_line), .auto_eoi_i(auto_eoi_i),
    .cmd_valid_i(cmd_valid_i), .cmd_code_i(cmd_code_i), .cmd_level_i(cmd_level_i),
    .top_any_i(t_any), .top_line_i(t_line),
    .isr_o(isr_n), .base_o(base_n), .rot_o(rot_n));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q  <= '0;
      base_q <= '0;
      rot_q  <= 1'b0;
      irq_o  <= 1'b0;
      line_o <= IDLE_LINE;
    end else begin
      isr_q  <= isr_n;
      base_q <= base_n;
      rot_q  <= rot_n;
      irq_o  <= want;
      line_o <= want ? p_line : IDLE_LINE;
    end
  end

  assign isr_o = isr_q;
endmodule

// File: rtl/irq_rank_chk.sv
module irq_rank_chk #(
  parameter int N_LINES = 8,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_LINES-1:0] pend_i,
  input logic [N_LINES-1:0] mask_i,
  input logic               ack_i,
  input logic               cmd_valid_i,
  input logic [2:0]         cmd_code_i,
  input logic               auto_eoi_i,
  input logic               irq_o,
  input logic [IDX_W-1:0]   line_o,
  input logic [N_LINES-1:0] isr_o
);
  logic [N_LINES-1:0] elig_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) elig_q <= '0;
    else         elig_q <= pend_i & ~mask_i;
  end

  assert_isr_set_needs_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((isr_o & ~$past(isr_o)) != '0) |-> $past(ack_i));

  assert_one_new_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(isr_o & ~$past(isr_o)) <= 1);

  assert_irq_line_eligible_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> elig_q[line_o]);

  assert_idle_line_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (line_o == IDX_W'(N_LINES - 1)));

  assert_auto_eoi_keeps_isr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && auto_eoi_i) |=> (isr_o == $past(isr_o)));

  assert_nop_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_code_i == 3'd2 && !ack_i) |=> $stable(isr_o));

  assert_isr_drop_needs_cmd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(isr_o) & ~isr_o) != '0) |-> $past(cmd_valid_i && !ack_i));
endmodule

bind irq_rank_resolver irq_rank_chk #(.N_LINES(N_LINES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend_i), .mask_i(mask_i),
  .ack_i(ack_i), .cmd_valid_i(cmd_valid_i), .cmd_code_i(cmd_code_i),
  .auto_eoi_i(auto_eoi_i), .irq_o(irq_o), .line_o(line_o), .isr_o(isr_o));

// File: tb/sim_irq_rank_resolver.sv
module sim_irq_rank_resolver;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] pend_i = '0, mask_i = '0;
  logic       ack_i = 1'b0, cmd_valid_i = 1'b0;
  logic [2:0] cmd_code_i = '0, cmd_level_i = '0;
  logic       auto_eoi_i = 1'b0, sfn_i = 1'b0;
  logic       irq_o;
  logic [2:0] line_o;
  logic [7:0] isr_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  irq_rank_resolver u0 (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic out_chk(string tag, int irq, int line, int isr);
    chk({tag, " irq"}, irq_o, irq);
    chk({tag, " line"}, line_o, line);
    chk({tag, " isr"}, isr_o, isr);
  endtask

  task automatic tick2();
    @(negedge clk_i); @(negedge clk_i);
  endtask

  task automatic do_ack();
    ack_i = 1; @(negedge clk_i); ack_i = 0; @(negedge clk_i);
  endtask

  task automatic do_cmd(int code, int lvl);
    cmd_valid_i = 1; cmd_code_i = 3'(code); cmd_level_i = 3'(lvl);
    @(negedge clk_i); cmd_valid_i = 0; @(negedge clk_i);
  endtask

  task automatic t_reset();
    out_chk("R1 reset", 0, 7, 0);
  endtask

  task automatic t_latency();
    pend_i = 8'h08;
    #2 chk("R12 before edge", irq_o, 0);
    @(negedge clk_i);
    out_chk("R12 after edge", 1, 3, 0);
    pend_i = 0; tick2();
  endtask

  task automatic t_fixed();
    pend_i = 8'h24; tick2();
    out_chk("R2 base0", 1, 2, 0);
    mask_i = 8'h04; tick2();
    out_chk("R3 masked", 1, 5, 0);
    mask_i = 0; tick2();
  endtask

  task automatic t_ack_nest();
    do_ack();
    out_chk("R3 equal rank blocked", 0, 7, 8'h04);
    pend_i = 8'h25; tick2();
    out_chk("R3 higher nests", 1, 0, 8'h04);
    do_ack();
    chk("R5 ack sets bit", isr_o, 8'h05);
  endtask

  task automatic t_eoi_top();
    do_cmd(1, 0);
    chk("R7 code1", isr_o, 8'h04);
    do_cmd(5, 0);
    out_chk("R7 code5 rotate", 1, 5, 0);
  endtask

  task automatic t_set_base();
    do_ack();
    chk("R5 ack line5", isr_o, 8'h20);
    do_cmd(6, 1);
    out_chk("R9 code6", 1, 2, 8'h20);
  endtask

  task automatic t_eoi_lvl();
    do_cmd(3, 5);
    out_chk("R8 code3", 1, 2, 0);
    do_ack();
    chk("R5 ack line2", isr_o, 8'h04);
    do_cmd(7, 2);
    out_chk("R8 code7", 1, 5, 0);
  endtask

  task automatic t_auto();
    do_cmd(4, 0);
    auto_eoi_i = 1;
    do_ack();
    out_chk("R6 auto rotate", 1, 0, 0);
    do_cmd(0, 0);
    do_ack();
    out_chk("R10 rot cleared", 1, 0, 0);
    auto_eoi_i = 0;
  endtask

  task automatic t_nop();
    do_ack();
    out_chk("R5 ack line0", 0, 7, 8'h01);
    do_cmd(2, 0);
    out_chk("R10 code2", 0, 7, 8'h01);
    do_cmd(1, 0);
    chk("R7 code1 again", isr_o, 0);
  endtask

  task automatic t_sfn();
    do_cmd(6, 7);
    pend_i = 8'h04; tick2();
    out_chk("R9 base wraps", 1, 2, 0);
    do_ack();
    out_chk("R4 sfn off", 0, 7, 8'h04);
    sfn_i = 1; tick2();
    out_chk("R4 sfn on", 1, 2, 8'h04);
    sfn_i = 0; tick2();
  endtask

  task automatic t_spurious();
    pend_i = 0; tick2();
    do_ack();
    out_chk("R5 spurious", 0, 7, 8'h04);
  endtask

  task automatic t_both();
    pend_i = 8'h01; tick2();
    out_chk("R11 pre", 1, 0, 8'h04);
    ack_i = 1; cmd_valid_i = 1; cmd_code_i = 3; cmd_level_i = 2;
    @(negedge clk_i); ack_i = 0; cmd_valid_i = 0; @(negedge clk_i);
    chk("R11 cmd ignored", isr_o, 8'h05);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++; done = 1;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i); @(negedge clk_i);
    t_reset();
    rst_ni = 1; @(negedge clk_i);
    t_latency();
    t_fixed();
    t_ack_nest();
    t_eoi_top();
    t_set_base();
    t_eoi_lvl();
    t_auto();
    t_nop();
    t_sfn();
    t_spurious();
    t_both();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule